// File: doc/BRIEF.md
# Write Response Checker

This block is a passive observer placed beside a single-ID, in-order AXI write port. It watches three handshakes on the port:

- the address handshake, including the lock bit that marks an exclusive access;
- the data handshake, including the last-beat marker;
- the response handshake, including its 2-bit code.

The block drives nothing back onto the bus. A completed response handshake looks the same whatever the result, so the block judges each write only from the response code. It sorts every code into its own class, with a one-cycle event pulse and a running counter per class. A failing target and an address with no target are always kept apart.

The block also raises sticky flags for several protocol faults:

- a response that starts before the write data has finished;
- a response that has no completed burst to answer;
- an exclusive-success code returned for a normal write;
- a lock-bit record queue that is too shallow for the outstanding address handshakes;
- a response code that changes while the response is stalled.

A synchronous clear pulse resets the flags. Integration logic or a test harness reads the pulses, counters and flags directly.

Top module: `axi_wresp_monitor`

## Requirements
- R1: While rst_n is low, every event pulse, counter and flag reads zero on the next cycle.
- R2: Each response handshake (b_valid and b_ready both high) produces exactly one event pulse, one cycle later. The code picks the pulse: 2'b00 normal success drives ev_ok_o, 2'b01 exclusive success drives ev_exok_o, 2'b10 target error drives ev_tgt_err_o, and 2'b11 decode error (no target) drives ev_dec_err_o. In cycles without a handshake no pulse appears.
- R3: Each handshake adds one to the counter of its own code, visible one cycle later. Target errors and decode errors use separate counters. The clear input leaves the counters unchanged.
- R4: flag_early_o sets when a response starts while no completed data burst is waiting for an answer. A response starts when b_valid is high and the previous cycle was not a stalled response (b_valid high with b_ready low). A burst counts as complete only from the cycle after its last-beat handshake. A response that starts in the cycle right after the last beat, or any number of cycles later, sets nothing.
- R5: flag_orphan_o sets on a response handshake that happens while the count of completed bursts minus delivered responses is zero.
- R6: flag_exok_o sets on a response handshake that carries code 2'b01 when the oldest recorded address handshake had its lock bit low, or when no address handshake is recorded.
- R7: The lock bit of each address handshake is queued, and the oldest entry is dropped at each response handshake. An address handshake that meets a full queue (Q_DEPTH entries) with no response handshake in the same cycle sets flag_ovf_o, and its lock bit is discarded.
- R8: flag_unstable_o sets when b_valid stays high after a stalled cycle (b_valid high, b_ready low) and b_resp differs from its value in that stalled cycle.
- R9: Every flag holds once set. A clock edge with clr_i high clears all flags, except that a violation detected in that same cycle leaves its own flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all violation flags |
| aw_valid | input | 1 | Observed address valid |
| aw_ready | input | 1 | Observed address ready |
| aw_lock | input | 1 | Observed lock bit, high for an exclusive write |
| w_valid | input | 1 | Observed data valid |
| w_ready | input | 1 | Observed data ready |
| w_last | input | 1 | Observed last-beat marker |
| b_valid | input | 1 | Observed response valid |
| b_ready | input | 1 | Observed response ready |
| b_resp | input | 2 | Observed response code |
| ev_ok_o | output | 1 | Pulse: normal success accepted |
| ev_exok_o | output | 1 | Pulse: exclusive success accepted |
| ev_tgt_err_o | output | 1 | Pulse: target error accepted |
| ev_dec_err_o | output | 1 | Pulse: decode error accepted |
| cnt_ok_o | output | CNT_W | Normal success count |
| cnt_exok_o | output | CNT_W | Exclusive success count |
| cnt_tgt_err_o | output | CNT_W | Target error count |
| cnt_dec_err_o | output | CNT_W | Decode error count |
| flag_early_o | output | 1 | Sticky: response started before data completed |
| flag_orphan_o | output | 1 | Sticky: response with no completed burst |
| flag_exok_o | output | 1 | Sticky: exclusive success on a normal write |
| flag_ovf_o | output | 1 | Sticky: lock-bit queue overflow |
| flag_unstable_o | output | 1 | Sticky: code changed during a stall |

## Verification
The checks use several response patterns:

- Responses that start in the first cycle after the last beat, and others after a long gap, show that latency of any length stays unflagged. A response whose handshake coincides with the last beat is flagged as early.
- A response that rises early but is held until after the data shows that starting early differs from answering without data.
- Exclusive and normal writes both return code 2'b01, which separates legal from illegal exclusive success.
- Stalls with a steady code and with a changing code separate hold-off from instability.
- A run of address handshakes with no responses fills the queue past its depth.
- A clear that coincides with a fresh violation tests the clear priority.

// File: rtl/wresp_pkg.sv
package wresp_pkg;

  typedef enum logic [1:0] {
    RSP_NORMAL  = 2'b00,
    RSP_EXCL_OK = 2'b01,
    RSP_TGT_ERR = 2'b10,
    RSP_NO_TGT  = 2'b11
  } resp_e;

  localparam int NUM_CODES = 4;

  // Sticky flag update: a new violation wins over a clear in the same cycle.
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

  // True when a response handshake carries exclusive success that no
  // exclusive address handshake justifies.
  function automatic logic exok_illegal(input logic hs, input logic [1:0] code,
                                        input logic rec_empty, input logic rec_lock);
    return hs & (code == RSP_EXCL_OK) & (rec_empty | ~rec_lock);
  endfunction

endpackage

// File: rtl/wresp_lock_fifo.sv
module wresp_lock_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic din,
  input  logic pop,
  output logic head,
  output logic empty,
  output logic full,
  output logic drop
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  slot;
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [FILL_W-1:0] fill;
  logic              do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == FILL_W'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign drop    = push & full & ~do_pop;
  assign head    = slot[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot   <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) begin
        slot[wr_ptr] <= din;
        wr_ptr       <= ptr_step(wr_ptr);
      end
      if (do_pop) rd_ptr <= ptr_step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + FILL_W'(1);
        2'b01:   fill <= fill - FILL_W'(1);
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/wresp_burst_tracker.sv
module wresp_burst_tracker #(
  parameter int PEND_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wlast_hs,
  input  logic       b_hs,
  input  logic       b_valid,
  input  logic       b_ready,
  input  logic [1:0] b_resp,
  output logic       pend_zero,
  output logic       waiting,
  output logic [1:0] held_resp,
  output logic       resp_start,
  output logic       early_evt,
  output logic       orphan_evt,
  output logic       unstable_evt
);
  logic [PEND_W-1:0] pend;
  logic              inc, dec;

  assign pend_zero    = (pend == '0);
  assign inc          = wlast_hs & ~(&pend);
  assign dec          = b_hs & ~pend_zero;
  assign resp_start   = b_valid & ~waiting;
  assign early_evt    = resp_start & pend_zero;
  assign orphan_evt   = b_hs & pend_zero;
  assign unstable_evt = waiting & b_valid & (b_resp != held_resp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      waiting   <= 1'b0;
      held_resp <= 2'b00;
    end else begin
      case ({inc, dec})
        2'b10:   pend <= pend + PEND_W'(1);
        2'b01:   pend <= pend - PEND_W'(1);
        default: pend <= pend;
      endcase
      waiting   <= b_valid & ~b_ready;
      held_resp <= b_resp;
    end
  end
endmodule

// File: rtl/wresp_code_stats.sv
module wresp_code_stats
  import wresp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                b_hs,
  input  logic [1:0]                          b_resp,
  output logic [NUM_CODES-1:0]                ev,
  output logic [NUM_CODES-1:0][CNT_W-1:0]     cnt
);
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    logic hit;
    assign hit = b_hs & (b_resp == 2'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ev[g]  <= 1'b0;
        cnt[g] <= '0;
      end else begin
        ev[g] <= hit;
        if (hit) cnt[g] <= cnt[g] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/axi_wresp_monitor.sv
module axi_wresp_monitor
  import wresp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int Q_DEPTH = 4,
  parameter int PEND_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic             aw_lock,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             w_last,
  input  logic             b_valid,
  input  logic             b_ready,
  input  logic [1:0]       b_resp,
  output logic             ev_ok_o,
  output logic             ev_exok_o,
  output logic             ev_tgt_err_o,
  output logic             ev_dec_err_o,
  output logic [CNT_W-1:0] cnt_ok_o,
  output logic [CNT_W-1:0] cnt_exok_o,
  output logic [CNT_W-1:0] cnt_tgt_err_o,
  output logic [CNT_W-1:0] cnt_dec_err_o,
  output logic             flag_early_o,
  output logic             flag_orphan_o,
  output logic             flag_exok_o,
  output logic             flag_ovf_o,
  output logic             flag_unstable_o
);
  // Named handshake events, also used by the bound checker.
  logic aw_hs, wlast_hs, b_hs;
  assign aw_hs    = aw_valid & aw_ready;
  assign wlast_hs = w_valid & w_ready & w_last;
  assign b_hs     = b_valid & b_ready;

  logic q_head, q_empty, q_full, q_drop;
  wresp_lock_fifo #(.DEPTH(Q_DEPTH)) u_lockq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (aw_hs),
    .din   (aw_lock),
    .pop   (b_hs),
    .head  (q_head),
    .empty (q_empty),
    .full  (q_full),
    .drop  (q_drop)
  );

  logic       pend_zero, waiting, resp_start;
  logic [1:0] held_resp;
  logic       early_evt, orphan_evt, unstable_evt;
  wresp_burst_tracker #(.PEND_W(PEND_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .wlast_hs     (wlast_hs),
    .b_hs         (b_hs),
    .b_valid      (b_valid),
    .b_ready      (b_ready),
    .b_resp       (b_resp),
    .pend_zero    (pend_zero),
    .waiting      (waiting),
    .held_resp    (held_resp),
    .resp_start   (resp_start),
    .early_evt    (early_evt),
    .orphan_evt   (orphan_evt),
    .unstable_evt (unstable_evt)
  );

  logic [NUM_CODES-1:0]            ev_all;
  logic [NUM_CODES-1:0][CNT_W-1:0] cnt_all;
  wresp_code_stats #(.CNT_W(CNT_W)) u_stats (
    .clk    (clk),
    .rst_n  (rst_n),
    .b_hs   (b_hs),
    .b_resp (b_resp),
    .ev     (ev_all),
    .cnt    (cnt_all)
  );

  assign ev_ok_o       = ev_all[RSP_NORMAL];
  assign ev_exok_o     = ev_all[RSP_EXCL_OK];
  assign ev_tgt_err_o  = ev_all[RSP_TGT_ERR];
  assign ev_dec_err_o  = ev_all[RSP_NO_TGT];
  assign cnt_ok_o      = cnt_all[RSP_NORMAL];
  assign cnt_exok_o    = cnt_all[RSP_EXCL_OK];
  assign cnt_tgt_err_o = cnt_all[RSP_TGT_ERR];
  assign cnt_dec_err_o = cnt_all[RSP_NO_TGT];

  logic badex_evt;
  assign badex_evt = exok_illegal(b_hs, b_resp, q_empty, q_head);

  // Sticky violation flags.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_early_o    <= 1'b0;
      flag_orphan_o   <= 1'b0;
      flag_exok_o     <= 1'b0;
      flag_ovf_o      <= 1'b0;
      flag_unstable_o <= 1'b0;
    end else begin
      flag_early_o    <= sticky_next(flag_early_o,    clr_i, early_evt);
      flag_orphan_o   <= sticky_next(flag_orphan_o,   clr_i, orphan_evt);
      flag_exok_o     <= sticky_next(flag_exok_o,     clr_i, badex_evt);
      flag_ovf_o      <= sticky_next(flag_ovf_o,      clr_i, q_drop);
      flag_unstable_o <= sticky_next(flag_unstable_o, clr_i, unstable_evt);
    end
  end
endmodule

// File: rtl/axi_wresp_monitor_chk.sv
module axi_wresp_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             aw_hs,
  input logic             b_hs,
  input logic [1:0]       b_resp,
  input logic             q_full,
  input logic             early_evt,
  input logic             orphan_evt,
  input logic             badex_evt,
  input logic             unstable_evt,
  input logic [3:0]       ev,
  input logic [CNT_W-1:0] cnt_tgt,
  input logic [CNT_W-1:0] cnt_dec,
  input logic [4:0]       flags
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (ev == 4'b0 && flags == 5'b0 && cnt_tgt == '0 && cnt_dec == '0));
  // R2
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));
  a_r2_dec_event: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hs && b_resp == 2'b11) |=> ev[3]);
  a_r2_no_hs_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    !b_hs |=> ev == 4'b0);
  // R3
  a_r3_tgt_count: assert property (@(posedge clk) disable iff (!rst_n)
    ev[2] |-> cnt_tgt == $past(cnt_tgt) + CNT_W'(1));
  a_r3_dec_count: assert property (@(posedge clk) disable iff (!rst_n)
    ev[3] |-> cnt_dec == $past(cnt_dec) + CNT_W'(1));
  // R4
  a_r4_early_flag: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> flags[0]);
  // R5
  a_r5_orphan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_evt |=> flags[1]);
  // R6
  a_r6_exok_flag: assert property (@(posedge clk) disable iff (!rst_n)
    badex_evt |=> flags[2]);
  // R7
  a_r7_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs && q_full && !b_hs) |=> flags[3]);
  // R8
  a_r8_unstable_flag: assert property (@(posedge clk) disable iff (!rst_n)
    unstable_evt |=> flags[4]);
  // R9
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr_i) |=> flags[0]);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !orphan_evt) |=> !flags[1]);
endmodule

bind axi_wresp_monitor axi_wresp_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr_i        (clr_i),
  .aw_hs        (aw_hs),
  .b_hs         (b_hs),
  .b_resp       (b_resp),
  .q_full       (q_full),
  .early_evt    (early_evt),
  .orphan_evt   (orphan_evt),
  .badex_evt    (badex_evt),
  .unstable_evt (unstable_evt),
  .ev           ({ev_dec_err_o, ev_tgt_err_o, ev_exok_o, ev_ok_o}),
  .cnt_tgt      (cnt_tgt_err_o),
  .cnt_dec      (cnt_dec_err_o),
  .flags        ({flag_unstable_o, flag_ovf_o, flag_exok_o, flag_orphan_o, flag_early_o})
);

// File: tb/sim_axi_wresp_monitor.sv
`timescale 1ns/1ps
module sim_axi_wresp_monitor;
  localparam int CW = 16;
  localparam int QD = 4;

  logic clk = 1'b0, rst_n = 1'b0, clr_i = 1'b0;
  logic aw_valid = 0, aw_ready = 0, aw_lock = 0;
  logic w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0;
  logic [1:0] b_resp = 2'b00;
  logic ev_ok_o, ev_exok_o, ev_tgt_err_o, ev_dec_err_o;
  logic [CW-1:0] cnt_ok_o, cnt_exok_o, cnt_tgt_err_o, cnt_dec_err_o;
  logic flag_early_o, flag_orphan_o, flag_exok_o, flag_ovf_o, flag_unstable_o;

  always #2 clk = ~clk;

  axi_wresp_monitor #(.CNT_W(CW), .Q_DEPTH(QD), .PEND_W(4)) u0 (.*);

  int checks = 0, errors = 0;

  // Behavioural reference model.
  bit m_q[$];
  int m_pend = 0, m_cnt[4] = '{0, 0, 0, 0};
  bit [3:0] m_ev = 0;
  bit m_early = 0, m_orph = 0, m_exok = 0, m_ovf = 0, m_unst = 0;
  bit m_wait = 0;
  logic [1:0] m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_pend = 0; m_ev = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
      {m_early, m_orph, m_exok, m_ovf, m_unst} = 0;
      m_wait = 0; m_prev = 0;
    end else begin
      bit bhs, awhs, wl, ex, was_empty;
      bhs  = b_valid && b_ready;
      awhs = aw_valid && aw_ready;
      wl   = w_valid && w_ready && w_last;
      if (clr_i) {m_early, m_orph, m_exok, m_ovf, m_unst} = 0;
      m_ev = 0;
      if (bhs) begin
        m_ev[b_resp] = 1;
        m_cnt[b_resp] = (m_cnt[b_resp] + 1) % 65536;
      end
      if (b_valid && !m_wait && m_pend == 0) m_early = 1;
      if (bhs && m_pend == 0) m_orph = 1;
      if (m_wait && b_valid && b_resp != m_prev) m_unst = 1;
      was_empty = (m_q.size() == 0);
      ex = was_empty ? 0 : m_q[0];
      if (bhs && b_resp == 2'b01 && (was_empty || !ex)) m_exok = 1;
      if (bhs && !was_empty) void'(m_q.pop_front());
      if (awhs) begin
        if (m_q.size() < QD) m_q.push_back(aw_lock);
        else m_ovf = 1;
      end
      m_pend = m_pend + (wl ? 1 : 0) - ((bhs && m_pend > 0) ? 1 : 0);
      m_wait = b_valid && !b_ready;
      m_prev = b_resp;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    check(rst_n ? "R2 events" : "R1 events",
          {ev_dec_err_o, ev_tgt_err_o, ev_exok_o, ev_ok_o}, m_ev);
    check(rst_n ? "R3 ok count" : "R1 ok count", cnt_ok_o, m_cnt[0]);
    check("R3 exok count", cnt_exok_o, m_cnt[1]);
    check("R3 tgt count", cnt_tgt_err_o, m_cnt[2]);
    check("R3 dec count", cnt_dec_err_o, m_cnt[3]);
    check("R4 early flag", flag_early_o, m_early);
    check("R5 orphan flag", flag_orphan_o, m_orph);
    check("R6 exok flag", flag_exok_o, m_exok);
    check("R7 overflow flag", flag_ovf_o, m_ovf);
    check("R8 unstable flag", flag_unstable_o, m_unst);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready, clr_i} = 0;
    end
  endtask

  task automatic addr(bit lock);
    @(negedge clk);
    {w_valid, w_ready, w_last, b_valid, b_ready, clr_i} = 0;
    aw_valid = 1; aw_ready = 1; aw_lock = lock;
  endtask

  task automatic data(int beats);
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      {aw_valid, aw_ready, b_valid, b_ready, clr_i} = 0;
      w_valid = 1; w_ready = 1; w_last = (i == beats - 1);
    end
  endtask

  task automatic resp(logic [1:0] code, int stall, logic [1:0] late_code);
    @(negedge clk);
    {aw_valid, aw_ready, w_valid, w_ready, w_last, clr_i} = 0;
    b_valid = 1; b_ready = (stall == 0); b_resp = code;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      b_ready = (i == stall - 1);
      b_resp  = (i == stall - 1) ? late_code : code;
    end
    @(negedge clk);
    b_valid = 0; b_ready = 0;
  endtask

  task automatic write(bit lock, int beats, int gap, logic [1:0] code);
    addr(lock); data(beats); idle(gap); resp(code, 0, code);
  endtask

  task automatic clear;
    @(negedge clk);
    {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = 0;
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
    check("R9 cleared", {flag_early_o, flag_orphan_o, flag_exok_o, flag_ovf_o, flag_unstable_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    // R2/R3: each code, earliest legal response and a long gap (R4 no flag)
    write(0, 1, 0, 2'b00);
    write(0, 4, 60, 2'b10);
    write(0, 2, 0, 2'b11);
    write(1, 3, 5, 2'b01);           // R6 legal exclusive success
    write(1, 1, 0, 2'b00);
    check("R4 no early on legal timing", flag_early_o, 0);
    // R6: exclusive success on a normal write
    write(0, 1, 2, 2'b01);
    check("R6 flagged", flag_exok_o, 1);
    clear();
    // R4: response handshake coincides with last beat
    addr(0);
    @(negedge clk);
    {aw_valid, aw_ready} = 0;
    w_valid = 1; w_ready = 1; w_last = 1; b_valid = 1; b_ready = 1; b_resp = 2'b00;
    idle(2);
    check("R4 early set", flag_early_o, 1);
    check("R5 orphan set with early", flag_orphan_o, 1);
    // pending burst from above is now answered late
    resp(2'b00, 0, 2'b00);
    clear();
    // R4 without R5: response starts early, held until data completes
    addr(0);
    @(negedge clk);
    {aw_valid, aw_ready} = 0; b_valid = 1; b_ready = 0; b_resp = 2'b10;
    @(negedge clk);
    w_valid = 1; w_ready = 1; w_last = 1;
    @(negedge clk);
    {w_valid, w_ready, w_last} = 0; b_ready = 1;
    idle(2);
    check("R4 early held", flag_early_o, 1);
    check("R5 no orphan", flag_orphan_o, 0);
    clear();
    // R8: steady stall then changing stall
    addr(0); data(2); resp(2'b11, 3, 2'b11);
    check("R8 steady stall", flag_unstable_o, 0);
    addr(0); data(1); resp(2'b00, 2, 2'b10);
    idle(1);
    check("R8 changed during stall", flag_unstable_o, 1);
    clear();
    // R5: response with no write at all
    resp(2'b11, 0, 2'b11);
    idle(1);
    check("R5 orphan", flag_orphan_o, 1);
    clear();
    // R7: more address handshakes than queue depth
    for (int i = 0; i < QD; i++) addr(1);
    idle(1);
    check("R7 full, no overflow", flag_ovf_o, 0);
    addr(0);
    idle(1);
    check("R7 overflow", flag_ovf_o, 1);
    for (int i = 0; i < QD; i++) begin data(1); resp(2'b01, 0, 2'b01); end
    check("R6 queued locks honoured", flag_exok_o, 0);
    // R9: clear in same cycle as a new orphan keeps that flag
    @(negedge clk);
    clr_i = 1; b_valid = 1; b_ready = 1; b_resp = 2'b00;
    @(negedge clk);
    clr_i = 0; b_valid = 0; b_ready = 0;
    check("R9 set wins over clear", flag_orphan_o, 1);
    check("R9 others cleared", flag_ovf_o, 0);
    idle(4);
    check("R9 sticky hold", flag_orphan_o, 1);
    // R1: reset mid-run
    @(negedge clk); rst_n = 0;
    idle(2);
    check("R1 reset clears", {cnt_ok_o, cnt_dec_err_o, 3'b0, flag_orphan_o}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule